// File: doc/BRIEF.md
# Wide Multiply-Accumulate Execution Unit

This unit executes integer multiply instructions for a load/store core with fixed 32-bit instruction words. Its main operation treats two 64-bit registers as a 128-bit accumulator. It forms the full 128-bit unsigned product of two other 64-bit registers, adds that product to the accumulator and writes the sum back into the same two registers. It also executes plain multiplies that return either the low or the high 64 bits of the product. The unit contains its own 32-entry register file, which has two read ports and a two-lane write path, along with a pipelined multiplier and the issue control.

The two read ports are shared in time. A multiply reads its two factors in the cycle it issues. A multiply-accumulate reads its accumulator pair through the same two ports four cycles later, because the pair is needed only for the final add. In that cycle the issue slot is closed. A register preload port fills the file. Each writeback is visible on two result lanes, which report the enable, address and data of each write.

Top module: `wide_mac_unit`

## Requirements
- R1: After reset, `issue_ready` is 1, neither writeback lane is enabled, and every register reads as zero.
- R2: Instruction word fields: bits [31:27] name the accumulator-high register, bits [26:22] name the accumulator-low register (which is also the destination of a plain multiply), bits [21:17] name factor 1 and bits [16:12] name factor 2. Bits [1:0] select the operation: 0 is no-op, 1 is multiply-low, 2 is multiply-high and 3 is multiply-accumulate. Bits [11:2] are ignored.
- R3: A multiply-accumulate issued in cycle C writes {hi,lo} + f1*f2 modulo 2^128 in cycle C+5. Both lanes are enabled in that same cycle: the low lane carries the lower 64 bits to the low register and the high lane carries the upper 64 bits to the high register. A carry out of bit 127 is lost.
- R4: A multiply-low issued in cycle C puts product bits [63:0] on the low lane in cycle C+5, and the high lane stays idle. A multiply-high puts bits [127:64] on the high lane in cycle C+5, addressed to the destination field, and the low lane stays idle. A multiply-low followed by a multiply-high in the next cycle is accepted without a stall, so the two halves arrive in cycles C+5 and C+6.
- R5: While a multiply-accumulate is in its fourth cycle after issue, `issue_ready` is 0, because both read ports are busy with the accumulator pair. One cycle later, issue resumes.
- R6: An instruction whose factor registers, or whose accumulator registers if it is a multiply-accumulate, match a destination of an operation that has not yet written back is held with `issue_ready` at 0. It is accepted in the first cycle after that writeback.
- R7: When a multiply-accumulate names the same register for both accumulator halves, both halves read that register, and after writeback the register holds the high half.
- R8: A no-op is accepted, enables no writeback and leaves every register unchanged.
- R9: When `ld_en` is 1, `ld_data` is written into register `ld_addr` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction is offered |
| issue_instr | input | 32 | Instruction word |
| issue_ready | output | 1 | The offered instruction is accepted at this edge |
| ld_en | input | 1 | Register preload strobe |
| ld_addr | input | 5 | Preload register number |
| ld_data | input | XLEN | Preload value |
| wb_lo_en | output | 1 | Low lane writes this cycle |
| wb_lo_addr | output | 5 | Low lane register |
| wb_lo_data | output | XLEN | Low lane value |
| wb_hi_en | output | 1 | High lane writes this cycle |
| wb_hi_addr | output | 5 | High lane register |
| wb_hi_data | output | XLEN | High lane value |

## Verification
The bench uses the default build: 64-bit registers and a five-stage multiplier. This places the accumulator read in the fourth cycle after issue and the writeback in the fifth, so each port-sharing and hazard window can be hit on an exact cycle. The full 64-bit width allows all-ones factors, which drive carries through both partial-product columns of the split multiplier and out of bit 127 of the accumulator sum. Expected sums come from plain 128-bit arithmetic in the bench.

// File: rtl/wide_mac_unit.sv
module wide_mac_unit #(
  parameter int XLEN    = 64,
  parameter int MUL_LAT = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [31:0]     issue_instr,
  output logic            issue_ready,
  input  logic            ld_en,
  input  logic [4:0]      ld_addr,
  input  logic [XLEN-1:0] ld_data,
  output logic            wb_lo_en,
  output logic [4:0]      wb_lo_addr,
  output logic [XLEN-1:0] wb_lo_data,
  output logic            wb_hi_en,
  output logic [4:0]      wb_hi_addr,
  output logic [XLEN-1:0] wb_hi_data
);
  localparam int H    = XLEN / 2;
  localparam int PW   = 2 * XLEN;
  localparam int NREG = 32;
  localparam int LAST = MUL_LAT - 1;
  localparam int ARD  = MUL_LAT - 2;
  localparam logic [1:0] OP_NOP  = 2'd0;
  localparam logic [1:0] OP_MULL = 2'd1;
  localparam logic [1:0] OP_MULH = 2'd2;
  localparam logic [1:0] OP_MAC  = 2'd3;

  logic [1:0] op_i;
  logic [4:0] f_ahi, f_alo, f_rs1, f_rs2;
  logic       unused_fields;
  assign op_i  = issue_instr[1:0];
  assign f_ahi = issue_instr[31:27];
  assign f_alo = issue_instr[26:22];
  assign f_rs1 = issue_instr[21:17];
  assign f_rs2 = issue_instr[16:12];
  assign unused_fields = ^issue_instr[11:2];

  logic [XLEN-1:0] rf [NREG];

  logic [MUL_LAT-1:0] p_v;
  logic [1:0]         p_op [MUL_LAT];
  logic [4:0]         p_hi [MUL_LAT];
  logic [4:0]         p_lo [MUL_LAT];

  logic acc_rd, haz, fire;
  logic [MUL_LAT-1:0] st_hit;
  assign acc_rd = p_v[ARD] && (p_op[ARD] == OP_MAC);

  logic [4:0]      rd_a0, rd_a1;
  logic [XLEN-1:0] rd_d0, rd_d1;
  assign rd_a0 = acc_rd ? p_hi[ARD] : f_rs1;
  assign rd_a1 = acc_rd ? p_lo[ARD] : f_rs2;
  assign rd_d0 = rf[rd_a0];
  assign rd_d1 = rf[rd_a1];

  for (genvar k = 0; k < MUL_LAT; k++) begin : g_hit
    logic [4:0] dl, dh;
    logic       pair;
    assign dl   = p_lo[k];
    assign dh   = p_hi[k];
    assign pair = (p_op[k] == OP_MAC);
    assign st_hit[k] = p_v[k] && (
        f_rs1 == dl || f_rs2 == dl ||
        (pair && (f_rs1 == dh || f_rs2 == dh)) ||
        (op_i == OP_MAC && (f_ahi == dl || f_alo == dl ||
                            (pair && (f_ahi == dh || f_alo == dh)))));
  end

  assign haz         = (|st_hit) && (op_i != OP_NOP);
  assign issue_ready = !acc_rd && !haz;
  assign fire        = issue_valid && issue_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_v <= '0;
      for (int k = 0; k < MUL_LAT; k++) begin
        p_op[k] <= OP_NOP;
        p_hi[k] <= '0;
        p_lo[k] <= '0;
      end
    end else begin
      p_v[0]  <= fire && (op_i != OP_NOP);
      p_op[0] <= op_i;
      p_hi[0] <= f_ahi;
      p_lo[0] <= f_alo;
      for (int k = 1; k < MUL_LAT; k++) begin
        p_v[k]  <= p_v[k-1];
        p_op[k] <= p_op[k-1];
        p_hi[k] <= p_hi[k-1];
        p_lo[k] <= p_lo[k-1];
      end
    end
  end

  logic [XLEN-1:0] pp_ll, pp_lh, pp_hl, pp_hh;
  always_ff @(posedge clk) begin
    if (fire) begin
      pp_ll <= {{H{1'b0}}, rd_d0[H-1:0]} * {{H{1'b0}}, rd_d1[H-1:0]};
      pp_lh <= {{H{1'b0}}, rd_d0[H-1:0]} * {{H{1'b0}}, rd_d1[XLEN-1:H]};
      pp_hl <= {{H{1'b0}}, rd_d0[XLEN-1:H]} * {{H{1'b0}}, rd_d1[H-1:0]};
      pp_hh <= {{H{1'b0}}, rd_d0[XLEN-1:H]} * {{H{1'b0}}, rd_d1[XLEN-1:H]};
    end
  end

  logic [XLEN+1:0] s1_lo;
  logic [XLEN-1:0] s1_hh;
  logic [H-1:0]    s1_lh, s1_hl;
  always_ff @(posedge clk) begin
    s1_lo <= {2'b0, pp_ll} + {2'b0, pp_lh[H-1:0], {H{1'b0}}}
                           + {2'b0, pp_hl[H-1:0], {H{1'b0}}};
    s1_hh <= pp_hh;
    s1_lh <= pp_lh[XLEN-1:H];
    s1_hl <= pp_hl[XLEN-1:H];
  end

  logic [PW-1:0] prod_q [MUL_LAT-2];
  always_ff @(posedge clk) begin
    prod_q[0] <= {s1_hh + {{H{1'b0}}, s1_lh} + {{H{1'b0}}, s1_hl}
                        + {{(XLEN-2){1'b0}}, s1_lo[XLEN+1:XLEN]},
                  s1_lo[XLEN-1:0]};
  end

  for (genvar j = 1; j < MUL_LAT - 2; j++) begin : g_dly
    always_ff @(posedge clk) prod_q[j] <= prod_q[j-1];
  end

  logic [PW-1:0] acc_q, prod_f, sum_f;
  always_ff @(posedge clk) begin
    if (acc_rd) acc_q <= {rd_d0, rd_d1};
  end

  assign prod_f = prod_q[MUL_LAT-3];
  assign sum_f  = prod_f + acc_q;

  logic       w_mac;
  assign w_mac = p_op[LAST] == OP_MAC;

  assign wb_lo_en   = p_v[LAST] && (w_mac || p_op[LAST] == OP_MULL);
  assign wb_lo_addr = p_lo[LAST];
  assign wb_lo_data = w_mac ? sum_f[XLEN-1:0] : prod_f[XLEN-1:0];
  assign wb_hi_en   = p_v[LAST] && (w_mac || p_op[LAST] == OP_MULH);
  assign wb_hi_addr = w_mac ? p_hi[LAST] : p_lo[LAST];
  assign wb_hi_data = w_mac ? sum_f[PW-1:XLEN] : prod_f[PW-1:XLEN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) rf[r] <= '0;
    end else begin
      if (ld_en)    rf[ld_addr]    <= ld_data;
      if (wb_lo_en) rf[wb_lo_addr] <= wb_lo_data;
      if (wb_hi_en) rf[wb_hi_addr] <= wb_hi_data;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !wb_lo_en && !wb_hi_en && issue_ready);

  // R5
  acc_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> !p_v[0]);

  // R3
  mac_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_lo_en && wb_hi_en) |-> $past(acc_rd));

  // R6
  acc_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_lo_en |-> !(p_v[0] && p_op[0] == OP_MAC &&
                   (p_hi[0] == wb_lo_addr || p_lo[0] == wb_lo_addr)));
endmodule

// File: tb/test_wide_mac_unit.sv
module test_wide_mac_unit;
  localparam int XLEN = 64;
  localparam int LAT  = 5;
  localparam logic [1:0] NOP = 2'd0, MULL = 2'd1, MULH = 2'd2, MAC = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid, issue_ready, ld_en, wb_lo_en, wb_hi_en;
  logic [31:0] issue_instr;
  logic [4:0]  ld_addr, wb_lo_addr, wb_hi_addr;
  logic [XLEN-1:0] ld_data, wb_lo_data, wb_hi_data;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  wide_mac_unit #(.XLEN(XLEN), .MUL_LAT(LAT)) i_wide_mac_unit (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_instr(issue_instr),
    .issue_ready(issue_ready), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .wb_lo_en(wb_lo_en), .wb_lo_addr(wb_lo_addr), .wb_lo_data(wb_lo_data),
    .wb_hi_en(wb_hi_en), .wb_hi_addr(wb_hi_addr), .wb_hi_data(wb_hi_data));

  localparam logic [257:0] VEC [8] = '{
    {MAC,  64'd3, 64'd5, 64'd0, 64'd7},
    {MAC,  64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd1},
    {MAC,  64'd1, 64'd1, 64'd5, 64'hFFFF_FFFF_FFFF_FFFF},
    {MAC,  64'd1, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {MULL, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'd9, 64'd9},
    {MULH, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'd9, 64'd9},
    {MULH, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd0},
    {MAC,  64'hDEAD_BEEF_0000_0001, 64'h0000_0001_FFFF_FFFF,
           64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210}
  };

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] h, l, s1, s2);
    return {h, l, s1, s2, 10'd0, op};
  endfunction

  function automatic logic [127:0] mul128(input logic [63:0] a, b);
    logic [127:0] x, y;
    x = {64'd0, a};
    y = {64'd0, b};
    return x * y;
  endfunction

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [4:0] a, input logic [63:0] d);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic issue_one(input string tag, input logic [31:0] ins);
    issue_valid = 1'b1; issue_instr = ins;
    #1 chk(tag, issue_ready, 1'b1);
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [127:0] p, s;
    logic quiet;
    issue_valid = 1'b0; issue_instr = '0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state and zeroed registers
    chk("R1 ready", issue_ready, 1'b1);
    chk("R1 lanes idle", {wb_lo_en, wb_hi_en}, 2'b00);
    issue_one("R1 issue", mk(MULL, 5'd0, 5'd7, 5'd5, 5'd6));
    step(4);
    chk("R1 zero regs", {wb_lo_en, wb_lo_addr, wb_lo_data}, {1'b1, 5'd7, 64'd0});
    step(1);

    // R3 R4 vector walk
    for (int i = 0; i < 8; i++) begin
      logic [1:0] op;
      logic [63:0] a, b, ah, al;
      {op, a, b, ah, al} = VEC[i];
      load(5'd1, a); load(5'd2, b); load(5'd10, ah); load(5'd11, al);
      issue_one("R2 vector issue", mk(op, 5'd10, 5'd11, 5'd1, 5'd2));
      step(3);
      chk("R3/R4 not before latency", {wb_lo_en, wb_hi_en}, 2'b00);
      step(1);
      p = mul128(a, b);
      s = p + {ah, al};
      if (op == MAC)
        chk("R3 mac result", {wb_lo_en, wb_hi_en, wb_lo_addr, wb_hi_addr, wb_hi_data, wb_lo_data},
            {1'b1, 1'b1, 5'd11, 5'd10, s});
      else if (op == MULL)
        chk("R4 mull result", {wb_lo_en, wb_hi_en, wb_lo_addr, wb_lo_data},
            {1'b1, 1'b0, 5'd11, p[63:0]});
      else
        chk("R4 mulh result", {wb_lo_en, wb_hi_en, wb_hi_addr, wb_hi_data},
            {1'b0, 1'b1, 5'd11, p[127:64]});
      step(1);
    end

    // R4 back-to-back low then high
    load(5'd1, 64'hFFFF_0000_FFFF_0001); load(5'd2, 64'h8000_0000_0000_0003);
    p = mul128(64'hFFFF_0000_FFFF_0001, 64'h8000_0000_0000_0003);
    issue_one("R4 mull issue", mk(MULL, 5'd0, 5'd20, 5'd1, 5'd2));
    issue_one("R4 mulh back-to-back", mk(MULH, 5'd0, 5'd21, 5'd1, 5'd2));
    step(3);
    chk("R4 low half", {wb_lo_en, wb_hi_en, wb_lo_addr, wb_lo_data}, {1'b1, 1'b0, 5'd20, p[63:0]});
    step(1);
    chk("R4 high half", {wb_lo_en, wb_hi_en, wb_hi_addr, wb_hi_data}, {1'b0, 1'b1, 5'd21, p[127:64]});
    step(1);

    // R5 read-port sharing window
    load(5'd1, 64'd6); load(5'd2, 64'd7); load(5'd10, 64'd0); load(5'd11, 64'd1);
    issue_one("R5 mac issue", mk(MAC, 5'd10, 5'd11, 5'd1, 5'd2));
    step(3);
    issue_valid = 1'b1; issue_instr = mk(MULL, 5'd0, 5'd22, 5'd1, 5'd2);
    #1 chk("R5 blocked at acc read", issue_ready, 1'b0);
    step(1);
    chk("R5 reopened", issue_ready, 1'b1);
    chk("R5 mac wb", {wb_lo_en, wb_lo_data}, {1'b1, 64'd43});
    step(1);
    issue_valid = 1'b0;
    step(4);
    chk("R5 delayed mull wb", {wb_lo_en, wb_lo_addr, wb_lo_data}, {1'b1, 5'd22, 64'd42});
    step(1);

    // R6 accumulator hazard
    load(5'd1, 64'd3); load(5'd2, 64'd4); load(5'd10, 64'd0); load(5'd11, 64'd5);
    issue_valid = 1'b1; issue_instr = mk(MAC, 5'd10, 5'd11, 5'd1, 5'd2);
    #1 chk("R6 first accepted", issue_ready, 1'b1);
    step(1);
    chk("R6 stall start", issue_ready, 1'b0);
    step(4);
    chk("R6 stall at writeback", issue_ready, 1'b0);
    chk("R6 first result", {wb_hi_data, wb_lo_data}, {64'd0, 64'd17});
    step(1);
    chk("R6 released", issue_ready, 1'b1);
    step(1);
    issue_valid = 1'b0;
    step(4);
    chk("R6 second result", {wb_lo_en, wb_hi_data, wb_lo_data}, {1'b1, 64'd0, 64'd29});
    step(1);

    // R7 same register for both accumulator halves
    load(5'd12, 64'd5); load(5'd1, 64'd7); load(5'd3, 64'd1);
    issue_one("R7 issue", mk(MAC, 5'd12, 5'd12, 5'd1, 5'd3));
    step(4);
    chk("R7 lanes", {wb_lo_addr, wb_hi_addr, wb_lo_data, wb_hi_data}, {5'd12, 5'd12, 64'd12, 64'd5});
    step(1);
    issue_one("R7 readback issue", mk(MULL, 5'd0, 5'd13, 5'd12, 5'd3));
    step(4);
    chk("R7 high half kept", {wb_lo_en, wb_lo_data}, {1'b1, 64'd5});
    step(1);

    // R8 no-op
    issue_one("R8 nop accepted", mk(NOP, 5'd13, 5'd13, 5'd13, 5'd13));
    quiet = 1'b1;
    for (int c = 0; c < 6; c++) begin
      if (wb_lo_en || wb_hi_en) quiet = 1'b0;
      step(1);
    end
    chk("R8 no writeback", quiet, 1'b1);
    issue_one("R8 readback issue", mk(MULL, 5'd0, 5'd14, 5'd13, 5'd3));
    step(4);
    chk("R8 register unchanged", {wb_lo_en, wb_lo_data}, {1'b1, 64'd5});
    step(1);

    // R9 preload, R2 ignored bits
    load(5'd30, 64'hCAFE_F00D_1234_5678);
    issue_one("R2 padded issue", mk(MULL, 5'd0, 5'd31, 5'd30, 5'd3) | 32'h0000_0FFC);
    step(4);
    chk("R9/R2 preload readback", {wb_lo_en, wb_lo_addr, wb_lo_data},
        {1'b1, 5'd31, 64'hCAFE_F00D_1234_5678});
    step(2);
    finish_run();
  end
endmodule